// File: doc/BRIEF.md
# Sequential 16-Point Decimation-in-Frequency FFT Engine

This block turns sixteen signed real samples into their 16-bin discrete Fourier transform. All the arithmetic runs through one time-shared radix-2 butterfly, which works in place on a small complex working store. A host raises `start` while the engine is idle. It then offers the sixteen samples one at a time, marking each with `in_valid`. Samples may come with idle cycles between them.

Once the last sample is captured, the controller steps through the four butterfly stages. Each cycle it does one read-modify-write of a pair of entries. It then streams the bins out in natural frequency order, X(0) first and X(15) last. Because the in-place stages leave the bins in bit-reversed address order, the streaming stage reads address `bitrev(k)` for bin k. A `busy` level covers the whole job. A one-cycle `done` marks the final output beat.

Twiddle factors are fixed-point values with 14 fraction bits. Every complex product is cut back to 16 bits by dropping the low 14 bits, with no rounding. Sums and differences wrap at 16 bits. The 8-bit input range keeps all four stages inside that width.

Top module: `fft16_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done` and `out_valid` are all low.
- R2: A `start` seen while idle makes `busy` high from the next cycle. A `start` seen while busy is ignored: the job in progress is unchanged and no second job follows it.
- R3: In the load phase, each cycle with `in_valid` high stores the next sample. The samples fill addresses 0 to 15 in order. Each is sign-extended to 16 bits as the real part, with the imaginary part set to zero. `in_valid` has no effect outside the load phase.
- R4: Each butterfly writes a+b to its upper address and (a−b)·W to its lower address, with all additions and subtractions wrapping at 16 bits.
- R5: There are four stages of eight butterflies each. The pair distance is 8, 4, 2 and 1 in stages 1 to 4. For a pair at offset k within its group, the twiddle index is k, 2k, 4k and 0 in stages 1 to 4.
- R6: Twiddle W^k = cos(2πk/16) − j·sin(2πk/16) is held as two signed 16-bit words with 14 fraction bits. For example, 0x4000 is +1.0, W^1 = (0x3B21, 0xE782) and W^4 = (0x0000, 0xC000).
- R7: The complex product forms the 32-bit values ar·wr − ai·wi and ar·wi + ai·wr, and keeps bits 29:14 of each as the 16-bit result, truncating.
- R8: The sixteen results leave on sixteen consecutive `out_valid` beats in natural order X(0)..X(15). `out_last` is high only on the X(15) beat.
- R9: `done` is high for exactly the cycle that carries `out_last`, and `busy` is low in that cycle.
- R10: The first `out_valid` beat appears 33 clock edges after the edge that captures the sixteenth sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (only acted on while idle) |
| in_valid | input | 1 | Sample strobe during the load phase |
| in_sample | input | IN_W (8) | Signed real input sample |
| busy | output | 1 | High from job start to the last output beat |
| done | output | 1 | One-cycle pulse with the last output beat |
| out_valid | output | 1 | Output bin is valid |
| out_last | output | 1 | Marks X(15) |
| out_re | output | DW (16) | Real part of the output bin |
| out_im | output | DW (16) | Imaginary part of the output bin |

## Verification
An all-ones frame must put exactly 16 in X(0) and zero everywhere else, which exposes any sum/difference or leg swap. A scaled impulse must give a flat spectrum, which separates sign extension and load addressing from the butterfly arithmetic. A ramp, a full-scale alternating pattern and seeded random frames exercise every twiddle value and every truncation of a negative product. Against a bench-side transform with the same truncation, these catch a wrong twiddle, a wrong stage span or a wrong bit slice. Frames that strobe `in_valid` with gaps, inject `start` and `in_valid` while the engine is computing or draining, and strobe samples while idle show whether such stimulus leaks into the job.

// File: rtl/fft16_pkg.sv
package fft16_pkg;

  localparam int LOG2N = 4;
  localparam int N     = 1 << LOG2N;
  localparam int HALF  = N / 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CALC,
    ST_DRAIN
  } fft_state_t;

  // reverse the bit order of an address
  function automatic logic [LOG2N-1:0] bitrev(input logic [LOG2N-1:0] v);
    logic [LOG2N-1:0] r;
    for (int i = 0; i < LOG2N; i++) r[i] = v[LOG2N-1-i];
    return r;
  endfunction

endpackage

// File: rtl/fft16_twiddle_rom.sv
module fft16_twiddle_rom (
  input  logic        [2:0]  idx,
  output logic signed [15:0] w_re,
  output logic signed [15:0] w_im
);

  // W16^k, cos and -sin, 14 fraction bits
  always_comb begin
    case (idx)
      3'd0:    begin w_re = 16'sh4000; w_im = 16'sh0000; end
      3'd1:    begin w_re = 16'sh3B21; w_im = 16'shE782; end
      3'd2:    begin w_re = 16'sh2D41; w_im = 16'shD2BF; end
      3'd3:    begin w_re = 16'sh187E; w_im = 16'shC4DF; end
      3'd4:    begin w_re = 16'sh0000; w_im = 16'shC000; end
      3'd5:    begin w_re = 16'shE782; w_im = 16'shC4DF; end
      3'd6:    begin w_re = 16'shD2BF; w_im = 16'shD2BF; end
      default: begin w_re = 16'shC4DF; w_im = 16'shE782; end
    endcase
  end

endmodule

// File: rtl/fft16_butterfly.sv
module fft16_butterfly #(
  parameter int DW   = 16,
  parameter int TW_W = 16,
  parameter int FRAC = 14
) (
  input  logic signed [DW-1:0]   a_re,
  input  logic signed [DW-1:0]   a_im,
  input  logic signed [DW-1:0]   b_re,
  input  logic signed [DW-1:0]   b_im,
  input  logic signed [TW_W-1:0] w_re,
  input  logic signed [TW_W-1:0] w_im,
  output logic signed [DW-1:0]   up_re,
  output logic signed [DW-1:0]   up_im,
  output logic signed [DW-1:0]   lo_re,
  output logic signed [DW-1:0]   lo_im
);

  localparam int PW = DW + TW_W;

  logic signed [DW-1:0] d_re, d_im;
  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir, acc_re, acc_im;

  always_comb begin
    up_re = a_re + b_re;
    up_im = a_im + b_im;
    d_re  = a_re - b_re;
    d_im  = a_im - b_im;
    p_rr  = PW'(d_re) * PW'(w_re);
    p_ii  = PW'(d_im) * PW'(w_im);
    p_ri  = PW'(d_re) * PW'(w_im);
    p_ir  = PW'(d_im) * PW'(w_re);
    acc_re = p_rr - p_ii;
    acc_im = p_ri + p_ir;
    lo_re = acc_re[FRAC+DW-1:FRAC];
    lo_im = acc_im[FRAC+DW-1:FRAC];
  end

endmodule

// File: rtl/fft16_ctrl.sv
module fft16_ctrl
  import fft16_pkg::*;
#(
  parameter int STAGES = LOG2N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             in_valid,
  output logic             busy,
  output logic             load_we,
  output logic [LOG2N-1:0] load_addr,
  output logic             calc_en,
  output logic [LOG2N-1:0] addr_a,
  output logic [LOG2N-1:0] addr_b,
  output logic [LOG2N-2:0] tw_idx,
  output logic             drain_en,
  output logic [LOG2N-1:0] drain_addr,
  output logic             drain_last
);

  localparam int AW        = LOG2N;
  localparam int TWW       = LOG2N - 1;
  localparam int SW        = $clog2(STAGES);
  localparam int CW        = SW + LOG2N - 1;
  localparam int CALC_LAST = STAGES * HALF - 1;

  fft_state_t      state;
  logic [CW-1:0]   cnt;
  logic [SW-1:0]   stage;
  logic [TWW-1:0]  bf;
  logic [AW-1:0]   span, koff, grp, base;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_LOAD;
        end
        ST_LOAD: begin
          if (in_valid) begin
            if (cnt == CW'(N - 1)) begin
              cnt   <= '0;
              state <= ST_CALC;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        ST_CALC: begin
          if (cnt == CW'(CALC_LAST)) begin
            cnt   <= '0;
            state <= ST_DRAIN;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_DRAIN: begin
          if (cnt == CW'(N - 1)) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // butterfly schedule: span halves each stage, twiddle step doubles
  always_comb begin
    stage  = cnt[CW-1:CW-SW];
    bf     = cnt[TWW-1:0];
    span   = AW'(1) << (AW'(LOG2N - 1) - AW'(stage));
    koff   = AW'(bf) & (span - AW'(1));
    grp    = AW'(bf) >> (AW'(LOG2N - 1) - AW'(stage));
    base   = (grp << (AW'(LOG2N) - AW'(stage))) | koff;
    addr_a = base;
    addr_b = base | span;
    tw_idx = TWW'(koff << stage);
  end

  assign busy       = (state != ST_IDLE);
  assign load_we    = (state == ST_LOAD) && in_valid;
  assign load_addr  = cnt[AW-1:0];
  assign calc_en    = (state == ST_CALC);
  assign drain_en   = (state == ST_DRAIN);
  assign drain_addr = bitrev(cnt[AW-1:0]);
  assign drain_last = (cnt == CW'(N - 1));

endmodule

// File: rtl/fft16_engine.sv
module fft16_engine
  import fft16_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int DW   = 16,
  parameter int TW_W = 16,
  parameter int FRAC = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_sample,
  output logic                   busy,
  output logic                   done,
  output logic                   out_valid,
  output logic                   out_last,
  output logic signed [DW-1:0]   out_re,
  output logic signed [DW-1:0]   out_im
);

  localparam int AW = LOG2N;

  logic             load_we, calc_en, drain_en, drain_last;
  logic [AW-1:0]    load_addr, addr_a, addr_b, drain_addr;
  logic [AW-2:0]    tw_idx;
  logic signed [TW_W-1:0] w_re, w_im;
  logic signed [DW-1:0]   up_re, up_im, lo_re, lo_im;
  logic signed [DW-1:0]   smp_ext;

  logic signed [DW-1:0] mem_re [N];
  logic signed [DW-1:0] mem_im [N];

  fft16_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .in_valid   (in_valid),
    .busy       (busy),
    .load_we    (load_we),
    .load_addr  (load_addr),
    .calc_en    (calc_en),
    .addr_a     (addr_a),
    .addr_b     (addr_b),
    .tw_idx     (tw_idx),
    .drain_en   (drain_en),
    .drain_addr (drain_addr),
    .drain_last (drain_last)
  );

  fft16_twiddle_rom u_rom (
    .idx  (tw_idx),
    .w_re (w_re),
    .w_im (w_im)
  );

  fft16_butterfly #(.DW(DW), .TW_W(TW_W), .FRAC(FRAC)) u_bfly (
    .a_re  (mem_re[addr_a]),
    .a_im  (mem_im[addr_a]),
    .b_re  (mem_re[addr_b]),
    .b_im  (mem_im[addr_b]),
    .w_re  (w_re),
    .w_im  (w_im),
    .up_re (up_re),
    .up_im (up_im),
    .lo_re (lo_re),
    .lo_im (lo_im)
  );

  assign smp_ext = {{(DW-IN_W){in_sample[IN_W-1]}}, in_sample};

  // working store: no reset, one load write or one butterfly pair per cycle
  always_ff @(posedge clk) begin
    if (load_we) begin
      mem_re[load_addr] <= smp_ext;
      mem_im[load_addr] <= '0;
    end else if (calc_en) begin
      mem_re[addr_a] <= up_re;
      mem_im[addr_a] <= up_im;
      mem_re[addr_b] <= lo_re;
      mem_im[addr_b] <= lo_im;
    end
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      done      <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= drain_en;
      out_last  <= drain_en && drain_last;
      done      <= drain_en && drain_last;
      out_re    <= drain_en ? mem_re[drain_addr] : '0;
      out_im    <= drain_en ? mem_im[drain_addr] : '0;
    end
  end

endmodule

// File: rtl/fft16_chk.sv
module fft16_chk
  import fft16_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic out_valid,
  input logic out_last
);

  logic [LOG2N-1:0] beat;

  always_ff @(posedge clk) begin
    if (rst) beat <= '0;
    else if (out_valid) beat <= out_last ? '0 : beat + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !done && !out_valid));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  // R8
  last_position_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_last == (beat == LOG2N'(N - 1))));

  // R8
  stream_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);

  // R9
  done_with_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_last && out_valid && !busy));

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

endmodule

bind fft16_engine fft16_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .out_valid (out_valid),
  .out_last  (out_last)
);

// File: tb/tb_fft16_engine.sv
`timescale 1ns/1ps
module tb_fft16_engine;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [7:0] in_sample = '0;
  logic              busy, done, out_valid, out_last;
  logic signed [15:0] out_re, out_im;

  int n_vec = 0;
  int n_bad = 0;
  int tw_re [8];
  int tw_im [8];
  int got_re [16];
  int got_im [16];

  always #2.5 clk = ~clk;

  fft16_engine dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_sample(in_sample), .busy(busy), .done(done),
    .out_valid(out_valid), .out_last(out_last),
    .out_re(out_re), .out_im(out_im)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int w16(input int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int brev4(input int v);
    return ((v & 1) << 3) | ((v & 2) << 1) | ((v & 4) >> 1) | ((v & 8) >> 3);
  endfunction

  // bench-side transform: textbook in-place DIF with the same truncation
  task automatic ref_fft(input int x [16], output int er [16], output int ei [16]);
    int r [16];
    int m [16];
    for (int i = 0; i < 16; i++) begin r[i] = x[i]; m[i] = 0; end
    for (int len = 16; len >= 2; len = len / 2) begin
      for (int g = 0; g < 16; g += len) begin
        for (int j = 0; j < len / 2; j++) begin
          int a, b, dr, di, pr, pi, t;
          a  = g + j;
          b  = a + len / 2;
          t  = j * (16 / len);
          dr = w16(r[a] - r[b]);
          di = w16(m[a] - m[b]);
          r[a] = w16(r[a] + r[b]);
          m[a] = w16(m[a] + m[b]);
          pr = dr * tw_re[t] - di * tw_im[t];
          pi = dr * tw_im[t] + di * tw_re[t];
          r[b] = w16(pr >>> 14);
          m[b] = w16(pi >>> 14);
        end
      end
    end
    for (int k = 0; k < 16; k++) begin er[k] = r[brev4(k)]; ei[k] = m[brev4(k)]; end
  endtask

  // one job: optional gaps in the sample strobe, optional stray start/in_valid
  task automatic run_frame(input int x [16], input bit gaps, input bit pokes);
    int er [16];
    int ei [16];
    int cyc;
    ref_fft(x, er, ei);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", int'(busy), 1);
    for (int i = 0; i < 16; i++) begin
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0;
        in_sample = 8'sh55;
        if (pokes) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      in_valid  = 1'b1;
      in_sample = 8'(x[i]);
      if (i < 15) @(negedge clk);
    end
    @(posedge clk);
    #1;
    in_valid  = pokes;
    in_sample = 8'sh7F;
    start     = pokes;
    cyc = 0;
    while (cyc < 100) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      in_sample = 8'(cyc * 37);
      if (out_valid) break;
    end
    // R10 latency from the edge that takes the last sample
    chk("R10", "first beat latency", cyc, 33);
    for (int k = 0; k < 16; k++) begin
      if (k == 5) start = pokes;
      if (k == 6) start = 1'b0;
      got_re[k] = int'(out_re);
      got_im[k] = int'(out_im);
      chk("R8", $sformatf("out_valid beat %0d", k), int'(out_valid), 1);
      chk("R8", $sformatf("out_last beat %0d", k), int'(out_last), int'(k == 15));
      chk("R9", $sformatf("done beat %0d", k), int'(done), int'(k == 15));
      chk("R5 R6 R7", $sformatf("X(%0d) re", k), got_re[k], er[k]);
      chk("R5 R6 R7", $sformatf("X(%0d) im", k), got_im[k], ei[k]);
      if (k == 15) chk("R9", "busy on last beat", int'(busy), 0);
      @(negedge clk);
    end
    start = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    // R2: stray start during the job started nothing
    chk("R2", "idle after job", int'(busy), 0);
    chk("R8", "no extra beat", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int x [16];
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) begin
      tw_re[k] = $rtoi($floor(16384.0 * $cos(6.283185307179586 * k / 16.0) + 0.5));
      tw_im[k] = $rtoi($floor(-16384.0 * $sin(6.283185307179586 * k / 16.0) + 0.5));
    end
    // R6 bench twiddle table agrees with the stated codes
    chk("R6", "W1 re", tw_re[1], 15137);
    chk("R6", "W1 im", tw_im[1], -6270);
    chk("R6", "W4 im", tw_im[4], -16384);

    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);

    // R3: strobes while idle are ignored
    in_valid = 1'b1;
    in_sample = 8'sh3C;
    repeat (4) @(negedge clk);
    chk("R3", "idle strobe no busy", int'(busy), 0);
    chk("R3", "idle strobe no output", int'(out_valid), 0);
    in_valid = 1'b0;

    // R4: all ones gives 16 in X(0), zero elsewhere
    for (int i = 0; i < 16; i++) x[i] = 1;
    run_frame(x, 1'b0, 1'b0);
    chk("R4", "ones X0", got_re[0], 16);
    chk("R4", "ones X1", got_re[1], 0);
    chk("R4", "ones X8", got_re[8], 0);

    // ramp with gaps in the strobe
    for (int i = 0; i < 16; i++) x[i] = 5 * (i + 1);
    run_frame(x, 1'b1, 1'b0);
    chk("R4", "ramp X0 sum", got_re[0], 680);

    // R3: negative impulse, sign extension and address 0
    for (int i = 0; i < 16; i++) x[i] = 0;
    x[0] = -100;
    run_frame(x, 1'b0, 1'b1);
    chk("R3", "impulse X7 re", got_re[7], -100);
    chk("R3", "impulse X13 im", got_im[13], 0);

    // full-scale negative and alternating
    for (int i = 0; i < 16; i++) x[i] = -128;
    run_frame(x, 1'b1, 1'b1);
    chk("R4", "min X0", got_re[0], -2048);
    for (int i = 0; i < 16; i++) x[i] = (i % 2 == 0) ? 127 : -128;
    run_frame(x, 1'b0, 1'b0);

    // seeded random frames, some with stray start/in_valid
    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < 16; i++) x[i] = int'($signed(8'($urandom)));
      run_frame(x, f[0], f[1]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule